// File: doc/BRIEF.md
# Associative Address Translation and Protection Unit

This block turns a 32-bit virtual address into a physical address. It first decides whether the address lies in a region that skips translation. If not, and translation is enabled, it searches a small fully associative table of page entries. Each entry has its own page size, an address-space tag, a shared flag, two protection bits and a dirty bit. Every lookup ends either with a physical address and an OK flag, or with a 12-bit exception code that a trap unit can use directly.

A request is presented for one cycle on `reqValid` together with the address, the access kind and the mode bits. The result is registered and appears on the response outputs in the next cycle. Entries are written one at a time through a load port, which a refill handler drives. The block does not choose the entry to replace and does not talk to any cache.

Top module: `assoc_xlate`

## Requirements
- R1: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high. After a cycle with no request, `rspValid`, `rspOk`, `rspCode` and `rspPaddr` are all zero.
- R2: While reset (`rstN` low) is held and after it, every response output is zero and every table entry is invalid.
- R3: A privileged access (`privMode`=1) to 0x80000000..0xBFFFFFFF succeeds for any access kind, with the physical address equal to the virtual address with bits 31..29 cleared. This holds whatever the value of `xlateOn`.
- R4: A privileged access at or above 0xE0000000 succeeds, with the physical address equal to the virtual address.
- R5: A user-mode access (`privMode`=0) to 0x80000000..0xBFFFFFFF, or to 0xE4000000..0xFFFFFFFF, fails with code 0x0E0 for read or fetch and 0x100 for write. A user-mode access to 0xE0000000..0xE3FFFFFF succeeds with the address unchanged.
- R6: With `xlateOn`=0, an address in 0x00000000..0x7FFFFFFF or 0xC0000000..0xDFFFFFFF succeeds for every kind and mode. Its physical address is the virtual address ANDed with 0x1FFFFFFF.
- R7: An entry covers a page whose size comes from the 2-bit size code: 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. The page base is the entry VPN shifted left by 10 with the in-page bits cleared. On a clean hit, the physical address is the entry PPN shifted left by 10 with the in-page bits cleared, ORed with the in-page offset of the virtual address.
- R8: Entries with the valid bit clear never match. The tag is compared with `curAsid` only when the entry is not shared and tag checking is active. Tag checking is inactive exactly when `singleSpace`=1 and `privMode`=1.
- R9: When two or more entries match, the result is code 0x140. This takes precedence over every protection check.
- R10: When no entry matches, the result is code 0x040 for read or fetch and 0x060 for write. Access kind encoding: 0 = read, 1 = write, 2 = fetch (3 behaves as read).
- R11: A user-mode hit on an entry whose protection bit 1 is clear fails with 0x0A0 for read or fetch and 0x0C0 for write. This check comes before R12.
- R12: A write that passes R11 fails with 0x0C0 if the entry's protection bit 0 is clear. Otherwise it fails with 0x080 if the entry's dirty bit is clear.
- R13: On success `rspOk`=1 and `rspCode`=0. On failure `rspOk`=0, `rspPaddr`=0 and `rspCode` is nonzero.
- R14: A load with `loadEn`=1 writes entry `loadIdx` at the clock edge. A lookup in the same cycle still sees the table as it was before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Virtual address |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| privMode | input | 1 | Core is in privileged mode |
| xlateOn | input | 1 | Translation enable |
| singleSpace | input | 1 | Single virtual space mode |
| curAsid | input | ASID_W | Current address-space tag |
| loadEn | input | 1 | Write one table entry |
| loadIdx | input | log2(NUM_ENTRIES) | Entry to write |
| loadVpn | input | 22 | Virtual page number (address bits 31..10) |
| loadAsid | input | ASID_W | Entry tag |
| loadPpn | input | PPN_W | Physical page number (address bits from 10 up) |
| loadSize | input | 2 | Page size code |
| loadProt | input | 2 | Bit 1: user access allowed; bit 0: write allowed |
| loadDirty | input | 1 | Dirty bit |
| loadShared | input | 1 | Shared page, ignores tag |
| loadValid | input | 1 | Entry valid |
| rspValid | output | 1 | Result present |
| rspOk | output | 1 | Access permitted |
| rspCode | output | 12 | Exception code, 0 on success |
| rspPaddr | output | 32 | Physical address, 0 on failure |

## Verification
The table is loaded with pages of all four sizes. It includes a shared page, a read-only page, a user-forbidden page, a page with a clear dirty bit, an overlapping pair and an invalid entry that aliases a valid one. Each page is hit at its first and last byte and just beyond its end, which separates a correct size mask from one that is off by one code. The same addresses are applied as read, write and fetch, in both modes, with tag checking on and off. This exposes any swap in the order of the permission checks and any confusion between the read and write code pairs. Bypass regions are probed at their edges (0x7FFFFFFF, 0x80000000, 0xDFFFFFFF, 0xE3FFFFFF, 0xE4000000) with translation on and off. A long pseudo-random stream that mixes lookups with loads is then compared every cycle against a behavioural model that decides a match by a range comparison rather than a mask.

// File: rtl/assoc_xlate_pkg.sv
package assoc_xlate_pkg;

  localparam int ADDR_W = 32;
  localparam int PAGE_LSB = 10;
  localparam int VPN_W = ADDR_W - PAGE_LSB;
  localparam int CODE_W = 12;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2
  } accKind_e;

  localparam logic [CODE_W-1:0] EXC_NONE      = 12'h000;
  localparam logic [CODE_W-1:0] EXC_MISS_RD   = 12'h040;
  localparam logic [CODE_W-1:0] EXC_MISS_WR   = 12'h060;
  localparam logic [CODE_W-1:0] EXC_FIRST_WR  = 12'h080;
  localparam logic [CODE_W-1:0] EXC_PROT_RD   = 12'h0A0;
  localparam logic [CODE_W-1:0] EXC_PROT_WR   = 12'h0C0;
  localparam logic [CODE_W-1:0] EXC_ADDR_RD   = 12'h0E0;
  localparam logic [CODE_W-1:0] EXC_ADDR_WR   = 12'h100;
  localparam logic [CODE_W-1:0] EXC_MULTI     = 12'h140;

  typedef enum logic [1:0] {
    PA_ZERO  = 2'd0,
    PA_LOW29 = 2'd1,
    PA_RAW   = 2'd2,
    PA_PAGE  = 2'd3
  } paSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic              capture;
    logic              ok;
    paSel_e            paSel;
    logic [CODE_W-1:0] code;
  } xlStrobe_t;

  // datapath -> control summary of the associative search
  typedef struct packed {
    logic       anyHit;
    logic       multiHit;
    logic [1:0] prot;
    logic       dirty;
  } hitInfo_t;

  // in-page offset mask for a size code
  function automatic logic [ADDR_W-1:0] pageMask(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    pageMask = 32'h0000_03FF;
      2'd1:    pageMask = 32'h0000_0FFF;
      2'd2:    pageMask = 32'h0000_FFFF;
      default: pageMask = 32'h000F_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/assoc_xlate_dp.sv
module assoc_xlate_dp
  import assoc_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ASID_W = 8,
  parameter int PPN_W = 19,
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1),
  localparam int PAD_W = ADDR_W - PAGE_LSB - PPN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              asidCheck,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [VPN_W-1:0]  loadVpn,
  input  logic [ASID_W-1:0] loadAsid,
  input  logic [PPN_W-1:0]  loadPpn,
  input  logic [1:0]        loadSize,
  input  logic [1:0]        loadProt,
  input  logic              loadDirty,
  input  logic              loadShared,
  input  logic              loadValid,
  input  xlStrobe_t         strb,
  output hitInfo_t          hitInfo,
  output logic              rspValid,
  output logic              rspOk,
  output logic [CODE_W-1:0] rspCode,
  output logic [ADDR_W-1:0] rspPaddr
);

  logic              entVld    [NUM_ENTRIES];
  logic [VPN_W-1:0]  entVpn    [NUM_ENTRIES];
  logic [ASID_W-1:0] entAsid   [NUM_ENTRIES];
  logic [PPN_W-1:0]  entPpn    [NUM_ENTRIES];
  logic [1:0]        entSize   [NUM_ENTRIES];
  logic [1:0]        entProt   [NUM_ENTRIES];
  logic              entDirty  [NUM_ENTRIES];
  logic              entShared [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
    logic [ADDR_W-1:0] offMask;
    logic tagOk;
    logic addrOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entVld[gi]    <= 1'b0;
        entVpn[gi]    <= '0;
        entAsid[gi]   <= '0;
        entPpn[gi]    <= '0;
        entSize[gi]   <= '0;
        entProt[gi]   <= '0;
        entDirty[gi]  <= 1'b0;
        entShared[gi] <= 1'b0;
      end else if (loadEn && (loadIdx == IDX_W'(gi))) begin
        entVld[gi]    <= loadValid;
        entVpn[gi]    <= loadVpn;
        entAsid[gi]   <= loadAsid;
        entPpn[gi]    <= loadPpn;
        entSize[gi]   <= loadSize;
        entProt[gi]   <= loadProt;
        entDirty[gi]  <= loadDirty;
        entShared[gi] <= loadShared;
      end
    end

    always_comb begin
      offMask = pageMask(entSize[gi]);
      tagOk   = entShared[gi] || !asidCheck || (entAsid[gi] == curAsid);
      addrOk  = (((reqAddr ^ {entVpn[gi], {PAGE_LSB{1'b0}}}) & ~offMask) == '0);
      matchVec[gi] = entVld[gi] && tagOk && addrOk;
    end
  end

  logic [CNT_W-1:0]  hitCnt;
  logic [IDX_W-1:0]  selIdx;
  logic [ADDR_W-1:0] selMask;
  logic [ADDR_W-1:0] pagePa;

  always_comb begin
    hitCnt = '0;
    selIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      hitCnt = hitCnt + CNT_W'(matchVec[i]);
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
    selMask = pageMask(entSize[selIdx]);
    pagePa  = ({{PAD_W{1'b0}}, entPpn[selIdx], {PAGE_LSB{1'b0}}} & ~selMask)
            | (reqAddr & selMask);
    hitInfo.anyHit   = (hitCnt != '0);
    hitInfo.multiHit = (hitCnt > CNT_W'(1));
    hitInfo.prot     = entProt[selIdx];
    hitInfo.dirty    = entDirty[selIdx];
  end

  logic [ADDR_W-1:0] nextPa;
  always_comb begin
    case (strb.paSel)
      PA_LOW29: nextPa = {3'b000, reqAddr[ADDR_W-4:0]};
      PA_RAW:   nextPa = reqAddr;
      PA_PAGE:  nextPa = pagePa;
      default:  nextPa = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspOk    <= 1'b0;
      rspCode  <= '0;
      rspPaddr <= '0;
    end else begin
      rspValid <= strb.capture;
      rspOk    <= strb.capture && strb.ok;
      rspCode  <= strb.capture ? strb.code : '0;
      rspPaddr <= strb.capture ? nextPa : '0;
    end
  end

endmodule

// File: rtl/assoc_xlate_ctrl.sv
module assoc_xlate_ctrl
  import assoc_xlate_pkg::*;
(
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic              privMode,
  input  logic              xlateOn,
  input  logic              singleSpace,
  input  hitInfo_t          hitInfo,
  output logic              asidCheck,
  output xlStrobe_t         strb
);

  logic isWrite;
  logic inDirect;
  logic inHigh;
  logic inUserWindow;

  always_comb begin
    isWrite      = (accKind_e'(reqKind) == KIND_WRITE);
    inDirect     = (reqAddr[31:30] == 2'b10);
    inHigh       = (reqAddr[31:29] == 3'b111);
    inUserWindow = (reqAddr[31:26] == 6'b111000);
    asidCheck    = !(singleSpace && privMode);

    strb = '{capture: 1'b0, ok: 1'b0, paSel: PA_ZERO, code: EXC_NONE};
    if (reqValid) begin
      strb.capture = 1'b1;
      if (inDirect || inHigh) begin
        if (!privMode && !inUserWindow) begin
          strb.code = isWrite ? EXC_ADDR_WR : EXC_ADDR_RD;
        end else begin
          strb.ok    = 1'b1;
          strb.paSel = inDirect ? PA_LOW29 : PA_RAW;
        end
      end else if (!xlateOn) begin
        strb.ok    = 1'b1;
        strb.paSel = PA_LOW29;
      end else if (hitInfo.multiHit) begin
        strb.code = EXC_MULTI;
      end else if (!hitInfo.anyHit) begin
        strb.code = isWrite ? EXC_MISS_WR : EXC_MISS_RD;
      end else if (!privMode && !hitInfo.prot[1]) begin
        strb.code = isWrite ? EXC_PROT_WR : EXC_PROT_RD;
      end else if (isWrite && !hitInfo.prot[0]) begin
        strb.code = EXC_PROT_WR;
      end else if (isWrite && !hitInfo.dirty) begin
        strb.code = EXC_FIRST_WR;
      end else begin
        strb.ok    = 1'b1;
        strb.paSel = PA_PAGE;
      end
    end
  end

endmodule

// File: rtl/assoc_xlate.sv
module assoc_xlate
  import assoc_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ASID_W = 8,
  parameter int PPN_W = 19,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic [1:0]        reqKind,
  input  logic              privMode,
  input  logic              xlateOn,
  input  logic              singleSpace,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [21:0]       loadVpn,
  input  logic [ASID_W-1:0] loadAsid,
  input  logic [PPN_W-1:0]  loadPpn,
  input  logic [1:0]        loadSize,
  input  logic [1:0]        loadProt,
  input  logic              loadDirty,
  input  logic              loadShared,
  input  logic              loadValid,
  output logic              rspValid,
  output logic              rspOk,
  output logic [11:0]       rspCode,
  output logic [31:0]       rspPaddr
);

  xlStrobe_t strb;
  hitInfo_t  hitInfo;
  logic      asidCheck;

  assoc_xlate_ctrl ctrl_i (
    .reqValid   (reqValid),
    .reqAddr    (reqAddr),
    .reqKind    (reqKind),
    .privMode   (privMode),
    .xlateOn    (xlateOn),
    .singleSpace(singleSpace),
    .hitInfo    (hitInfo),
    .asidCheck  (asidCheck),
    .strb       (strb)
  );

  assoc_xlate_dp #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ASID_W     (ASID_W),
    .PPN_W      (PPN_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .curAsid   (curAsid),
    .asidCheck (asidCheck),
    .loadEn    (loadEn),
    .loadIdx   (loadIdx),
    .loadVpn   (loadVpn),
    .loadAsid  (loadAsid),
    .loadPpn   (loadPpn),
    .loadSize  (loadSize),
    .loadProt  (loadProt),
    .loadDirty (loadDirty),
    .loadShared(loadShared),
    .loadValid (loadValid),
    .strb      (strb),
    .hitInfo   (hitInfo),
    .rspValid  (rspValid),
    .rspOk     (rspOk),
    .rspCode   (rspCode),
    .rspPaddr  (rspPaddr)
  );

endmodule

// File: rtl/assoc_xlate_chk.sv
module assoc_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic        privMode,
  input logic        xlateOn,
  input logic        rspValid,
  input logic        rspOk,
  input logic [11:0] rspCode,
  input logic [31:0] rspPaddr
);

  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspOk && rspCode == 12'h000 && rspPaddr == 32'h0));

  a_r13_ok_has_no_code: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOk) |-> (rspCode == 12'h000));

  a_r13_fault_clears_pa: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspOk) |-> (rspPaddr == 32'h0 && rspCode != 12'h000));

  a_r3_priv_direct_region: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && privMode && reqAddr[31:30] == 2'b10)
      |=> (rspOk && rspPaddr == {3'b000, $past(reqAddr[28:0])}));

  a_r5_user_direct_region: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !privMode && reqAddr[31:30] == 2'b10)
      |=> (!rspOk && (rspCode == 12'h0E0 || rspCode == 12'h100)));

  a_r6_xlate_off_low: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !xlateOn && !reqAddr[31])
      |=> (rspOk && rspPaddr == {3'b000, $past(reqAddr[28:0])}));

endmodule

bind assoc_xlate assoc_xlate_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqAddr (reqAddr),
  .privMode(privMode),
  .xlateOn (xlateOn),
  .rspValid(rspValid),
  .rspOk   (rspOk),
  .rspCode (rspCode),
  .rspPaddr(rspPaddr)
);

// File: tb/assoc_xlate_tb_top.sv
module assoc_xlate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NENT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        privMode = 1'b0;
  logic        xlateOn = 1'b0;
  logic        singleSpace = 1'b0;
  logic [7:0]  curAsid = '0;
  logic        loadEn = 1'b0;
  logic [2:0]  loadIdx = '0;
  logic [21:0] loadVpn = '0;
  logic [7:0]  loadAsid = '0;
  logic [18:0] loadPpn = '0;
  logic [1:0]  loadSize = '0;
  logic [1:0]  loadProt = '0;
  logic        loadDirty = 1'b0;
  logic        loadShared = 1'b0;
  logic        loadValid = 1'b0;
  logic        rspValid;
  logic        rspOk;
  logic [11:0] rspCode;
  logic [31:0] rspPaddr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_xlate dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqKind(reqKind),
    .privMode(privMode), .xlateOn(xlateOn), .singleSpace(singleSpace), .curAsid(curAsid),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadVpn(loadVpn), .loadAsid(loadAsid),
    .loadPpn(loadPpn), .loadSize(loadSize), .loadProt(loadProt), .loadDirty(loadDirty),
    .loadShared(loadShared), .loadValid(loadValid),
    .rspValid(rspValid), .rspOk(rspOk), .rspCode(rspCode), .rspPaddr(rspPaddr)
  );

  // ---------------- behavioural reference model ----------------
  bit          mVld [NENT];
  int unsigned mVpn [NENT];
  int unsigned mAsid[NENT];
  int unsigned mPpn [NENT];
  int unsigned mSize[NENT];
  int unsigned mProt[NENT];
  bit          mDirty[NENT];
  bit          mShared[NENT];

  bit          expValid = 0;
  bit          expOk = 0;
  int unsigned expCode = 0;
  int unsigned expPa = 0;
  string       expTag = "R2";

  function automatic longint pageBytes(int unsigned sz);
    case (sz)
      0: return 1024;
      1: return 4096;
      2: return 65536;
      default: return 1048576;
    endcase
  endfunction

  task automatic refEval(input int unsigned a, input int unsigned kind, input bit priv,
                         input bit xon, input bit ss, input int unsigned asid,
                         output bit ok, output int unsigned code, output int unsigned pa,
                         output string tag);
    bit wr;
    int hits;
    int which;
    longint base;
    longint sz;
    wr = (kind == 1);
    ok = 0; code = 0; pa = 0; tag = "R7";
    if (a >= 32'h8000_0000 && a <= 32'hBFFF_FFFF) begin
      if (!priv) begin tag = "R5"; code = wr ? 'h100 : 'h0E0; end
      else begin tag = "R3"; ok = 1; pa = a & 32'h1FFF_FFFF; end
      return;
    end
    if (a >= 32'hE000_0000) begin
      if (!priv && a >= 32'hE400_0000) begin tag = "R5"; code = wr ? 'h100 : 'h0E0; end
      else begin tag = priv ? "R4" : "R5"; ok = 1; pa = a; end
      return;
    end
    if (!xon) begin tag = "R6"; ok = 1; pa = a & 32'h1FFF_FFFF; return; end
    hits = 0; which = -1;
    for (int i = 0; i < NENT; i++) begin
      sz = pageBytes(mSize[i]);
      base = (longint'(mVpn[i]) << 10) & ~(sz - 1);
      if (mVld[i] && (mShared[i] || (ss && priv) || mAsid[i] == asid) &&
          longint'(a) >= base && longint'(a) <= base + sz - 1) begin
        hits++; which = i;
      end
    end
    if (hits > 1) begin tag = "R9"; code = 'h140; return; end
    if (hits == 0) begin tag = "R10"; code = wr ? 'h060 : 'h040; return; end
    if (!priv && mProt[which] < 2) begin tag = "R11"; code = wr ? 'h0C0 : 'h0A0; return; end
    if (wr && (mProt[which] % 2) == 0) begin tag = "R12"; code = 'h0C0; return; end
    if (wr && !mDirty[which]) begin tag = "R12"; code = 'h080; return; end
    if (mShared[which] || (ss && priv)) tag = "R8";
    ok = 1;
    sz = pageBytes(mSize[which]);
    pa = int'(((longint'(mPpn[which]) << 10) & ~(sz - 1)) | (longint'(a) & (sz - 1)));
  endtask

  always @(posedge clk) begin
    bit o; int unsigned c; int unsigned p; string t;
    if (!rstN) begin
      for (int i = 0; i < NENT; i++) mVld[i] = 0;
      expValid <= 0; expOk <= 0; expCode <= 0; expPa <= 0; expTag <= "R2";
    end else begin
      if (reqValid) begin
        refEval(reqAddr, reqKind, privMode, xlateOn, singleSpace, curAsid, o, c, p, t);
        expValid <= 1; expOk <= o; expCode <= c; expPa <= p; expTag <= t;
      end else begin
        expValid <= 0; expOk <= 0; expCode <= 0; expPa <= 0; expTag <= "R1";
      end
      // R14: the table is updated after the lookup of the same edge
      if (loadEn) begin
        mVld[loadIdx] = loadValid; mVpn[loadIdx] = loadVpn; mAsid[loadIdx] = loadAsid;
        mPpn[loadIdx] = loadPpn; mSize[loadIdx] = loadSize; mProt[loadIdx] = loadProt;
        mDirty[loadIdx] = loadDirty; mShared[loadIdx] = loadShared;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (rspValid !== expValid || rspOk !== expOk || rspCode !== 12'(expCode) ||
          rspPaddr !== 32'(expPa)) begin
        miscompares++;
        $display("FAIL %s: got v=%0b ok=%0b code=%03h pa=%08h, expected v=%0b ok=%0b code=%03h pa=%08h",
                 expTag, rspValid, rspOk, rspCode, rspPaddr, expValid, expOk, expCode[11:0], expPa);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic setLd(input int idx, input int unsigned vaBase, input int unsigned asid,
                       input int unsigned paBase, input int sz, input int prot,
                       input bit dirty, input bit shared, input bit valid);
    loadEn = 1; loadIdx = 3'(idx); loadVpn = vaBase[31:10]; loadAsid = 8'(asid);
    loadPpn = paBase[28:10]; loadSize = 2'(sz); loadProt = 2'(prot);
    loadDirty = dirty; loadShared = shared; loadValid = valid;
  endtask

  task automatic setRq(input int unsigned a, input int kind, input bit priv, input bit xon,
                       input bit ss, input int unsigned asid);
    reqValid = 1; reqAddr = a; reqKind = 2'(kind); privMode = priv;
    xlateOn = xon; singleSpace = ss; curAsid = 8'(asid);
  endtask

  task automatic ld(input int idx, input int unsigned vaBase, input int unsigned asid,
                    input int unsigned paBase, input int sz, input int prot,
                    input bit dirty, input bit shared, input bit valid);
    @(negedge clk); reqValid = 0;
    setLd(idx, vaBase, asid, paBase, sz, prot, dirty, shared, valid);
  endtask

  task automatic rq(input int unsigned a, input int kind, input bit priv, input bit xon,
                    input bit ss, input int unsigned asid);
    @(negedge clk); loadEn = 0;
    setRq(a, kind, priv, xon, ss, asid);
  endtask

  task automatic idle(input int n);
    @(negedge clk); reqValid = 0; loadEn = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  // all kinds in both modes, tag check on
  task automatic sweep(input int unsigned a, input int unsigned asid);
    for (int k = 0; k < 3; k++) begin
      rq(a, k, 1, 1, 0, asid);
      rq(a, k, 0, 1, 0, asid);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R1: watchdog expired, got no end of run, expected completion");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    int unsigned bases[12];
    // R2: outputs zero during reset (checked by the per-cycle compare)
    repeat (3) @(negedge clk);
    rstN = 1;
    idle(2);
    // R2: table empty after reset -> miss
    rq(32'h0040_0000, 0, 1, 1, 0, 5);

    // populate table
    ld(0, 32'h0040_0000, 5, 32'h1234_5000, 1, 3, 1, 0, 1);   // 4K rw
    ld(1, 32'h1000_0000, 7, 32'h0A00_0000, 3, 1, 1, 1, 1);   // 1M shared, user forbidden
    ld(2, 32'h0080_0000, 5, 32'h0155_5400, 0, 3, 0, 0, 1);   // 1K clean
    ld(3, 32'h2000_0000, 5, 32'h0777_0000, 2, 2, 1, 0, 1);   // 64K read-only
    ld(4, 32'h3000_0000, 5, 32'h0100_0000, 3, 3, 1, 0, 1);   // overlap pair
    ld(5, 32'h3000_1000, 5, 32'h0200_0000, 1, 3, 1, 0, 1);
    ld(6, 32'hC000_3000, 9, 32'h0333_3000, 1, 3, 1, 0, 1);   // P3 page
    ld(7, 32'h0040_0000, 5, 32'h0999_9000, 1, 3, 1, 0, 0);   // invalid alias (R8)
    idle(1);

    // R7: page edges of each size
    sweep(32'h0040_0000, 5); sweep(32'h0040_0FFF, 5); sweep(32'h0040_1000, 5);
    sweep(32'h0080_03FF, 5); sweep(32'h0080_0400, 5);             // R12 dirty clear
    sweep(32'h2000_FFFF, 5); sweep(32'h2001_0000, 5);             // R12 write-protect, R11
    sweep(32'h100F_FFFF, 3); sweep(32'h1010_0000, 3);             // R8 shared, R11
    sweep(32'h3000_1004, 5); sweep(32'h3000_2004, 5);             // R9 overlap vs single
    sweep(32'hC000_3ABC, 9); sweep(32'hC000_3ABC, 8);             // R10 tag mismatch
    // R8: tag check off only when single space and privileged
    rq(32'h0040_0123, 0, 1, 1, 1, 3);
    rq(32'h0040_0123, 0, 0, 1, 1, 3);
    // R3/R4/R5/R6 region edges, translation on and off
    for (int x = 0; x < 2; x++) begin
      rq(32'h7FFF_FFFF, 0, 1, x[0], 0, 5);
      rq(32'h8000_0000, 1, 1, x[0], 0, 5);
      rq(32'hBFFF_FFFF, 2, 0, x[0], 0, 5);
      rq(32'hA123_4567, 1, 0, x[0], 0, 5);
      rq(32'hDFFF_FFFF, 0, 0, x[0], 0, 5);
      rq(32'hE3FF_FFFF, 1, 0, x[0], 0, 5);
      rq(32'hE400_0000, 1, 0, x[0], 0, 5);
      rq(32'hE400_0000, 2, 0, x[0], 0, 5);
      rq(32'hFFFF_FFF0, 0, 1, x[0], 0, 5);
    end
    idle(2);
    // R14: overwrite entry 0 and look it up in the same cycle, then the cycle after
    @(negedge clk);
    setLd(0, 32'h0040_0000, 5, 32'h0ABC_D000, 1, 3, 1, 0, 1);
    setRq(32'h0040_0010, 0, 1, 1, 0, 5);
    rq(32'h0040_0010, 0, 1, 1, 0, 5);
    // R14: invalidate entry 4, overlap resolves
    ld(4, 32'h3000_0000, 5, 32'h0100_0000, 3, 3, 1, 0, 0);
    rq(32'h3000_1004, 1, 0, 1, 0, 5);
    idle(1);

    // pseudo-random stream with interleaved loads
    bases = '{32'h0040_0000, 32'h1000_0000, 32'h0080_0000, 32'h2000_0000, 32'h3000_0000,
              32'hC000_3000, 32'h8000_1234, 32'hA000_0010, 32'hE200_0040, 32'hE400_0000,
              32'hFFFF_0000, 32'h5000_0000};
    seed = 32'h1357_9BDF;
    for (int n = 0; n < 3000; n++) begin
      seed = seed * 1103515245 + 12345;
      if ((seed >> 28) == 0) begin
        ld(int'((seed >> 4) % 8), bases[(seed >> 8) % 6] + ((seed >> 12) & 32'h3000),
           ((seed >> 20) % 2) ? 5 : 7, (seed << 4) & 32'h1FFF_FC00, int'((seed >> 16) % 4),
           int'((seed >> 18) % 4), seed[22], seed[23], seed[24] | seed[25]);
      end else if ((seed >> 28) == 1) begin
        idle(1);
      end else begin
        rq(bases[(seed >> 8) % 12] + ((seed >> 3) & 32'h1_FFFF), int'((seed >> 22) % 4),
           seed[26], seed[27] | seed[21], seed[19], ((seed >> 14) % 2) ? 5 : 7);
      end
    end
    idle(3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule